// File: doc/BRIEF.md
# Circular Sampling Window Selector

A tuning sweep tries each of 16 receive sampling phases and records one pass/fail bit per phase. This block takes that 16-bit mask and picks the phase to use. It groups the passing phases into runs of adjacent phase numbers. Phase 15 and phase 0 count as neighbours, so a run that ends at 15 and a run that starts at 0 form one run across the wrap. From the longest run it takes the phase three quarters of the way in, not the midpoint.

The block is a sequential scanner. A pulse on `start_i` captures the mask. The block then walks the mask one phase per cycle. A fixed number of cycles after the start, it raises a one-cycle `done_o` together with either a valid phase or an error flag. The results hold until the next accepted start. The sweep that builds the mask and the logic that applies the chosen phase are outside this block.

Top module: `phase_window_select`

## Requirements
- R1: A run is a set of passing phases with strictly consecutive numbers. When valid, the reported phase is always one whose mask bit (bit n = phase n) is set.
- R2: When phase 0 passes and a different run ends at phase 15, the two runs merge into one run. The merged run starts at the first phase of the phase-15 run, and its length is the sum of the two lengths. If that sum reached 16 or more, the result would be an error.
- R3: The longest run is selected, and on a tie the earliest run wins. Runs are ordered by starting phase. A merged run takes the position of its phase-15 part, so a run lying between the two parts beats a merged run of equal length.
- R4: Let L be the length of the selected run. The offset is floor(3L/4), minus one when that value is nonzero. The phase reported is (run start + offset) mod 16.
- R5: An all-zero mask gives `err_o`=1 and `valid_o`=0 with `phase_o`=0. Any other mask gives `valid_o`=1 and `err_o`=0 at done.
- R6: An all-ones mask is a single 16-phase run with no merging, and it reports phase 11.
- R7: `done_o` is high for exactly one cycle. It rises on the 17th rising edge after the edge that accepted the start. `valid_o`, `err_o` and `phase_o` update on that same edge.
- R8: `start_i` is ignored while a scan is in progress. Between done and the next accepted start, the outputs hold. An accepted start clears `valid_o` and `err_o` and leaves `phase_o` unchanged.
- R9: After reset, `done_o`, `valid_o` and `err_o` are 0 and `phase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when idle |
| mask_i | input | 16 | Pass/fail mask, bit n = phase n passed |
| done_o | output | 1 | One-cycle result strobe |
| valid_o | output | 1 | A phase was selected |
| err_o | output | 1 | No usable window (empty mask) |
| phase_o | output | 4 | Selected sampling phase |

## Verification
The bench targets the wrap cases: a single passing phase at each end, 0x8001 merging into a two-phase run, and 0xC003 whose pick index wraps past 15 back to 0. A design that ignored the wrap, or that did not take the pick modulo 16, would report a phase on the wrong side of the window. It also covers ties between a merged run and an equal middle run, and between two equal ordinary runs. Ranking the merged run at phase 0 would flip the winner in those cases. The all-ones mask would produce an out-of-range or merged pick if the run were counted twice. The bench also covers the empty mask, a start issued mid-scan, and a set of random masks. Each case is compared every cycle against a behavioural model, and a design that re-triggered on the mid-scan start would produce an extra done.

// File: rtl/phsel_pkg.sv
package phsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/phsel_run_tracker.sv
module phsel_run_tracker #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int LW  = $clog2(NPH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          bit_i,
  input  logic [PW-1:0] pos_i,
  output logic          first_def_o,
  output logic [LW-1:0] first_len_o,
  output logic          last_def_o,
  output logic [PW-1:0] last_start_o,
  output logic [LW-1:0] last_len_o,
  output logic [PW-1:0] best_start_o,
  output logic [LW-1:0] best_len_o
);
  logic [LW-1:0] cur_len_q, ext_len;
  logic [PW-1:0] cur_start_q, c_start;
  logic [LW-1:0] c_len;
  logic          seen_q, closing, at_end;

  assign ext_len = cur_len_q + 1'b1;
  assign at_end  = (pos_i == PW'(NPH - 1));

  always_comb begin
    closing = 1'b0;
    c_len   = cur_len_q;
    c_start = cur_start_q;
    if (bit_i && at_end) begin
      closing = 1'b1;
      c_len   = ext_len;
      c_start = (cur_len_q == '0) ? pos_i : cur_start_q;
    end else if (!bit_i && cur_len_q != '0) begin
      closing = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      seen_q       <= 1'b0;
      first_def_o  <= 1'b0;
      first_len_o  <= '0;
      last_def_o   <= 1'b0;
      last_start_o <= '0;
      last_len_o   <= '0;
      best_start_o <= '0;
      best_len_o   <= '0;
    end else if (clear_i) begin
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      seen_q       <= 1'b0;
      first_def_o  <= 1'b0;
      first_len_o  <= '0;
      last_def_o   <= 1'b0;
      last_start_o <= '0;
      last_len_o   <= '0;
      best_start_o <= '0;
      best_len_o   <= '0;
    end else if (step_i) begin
      if (bit_i) begin
        if (cur_len_q == '0) cur_start_q <= pos_i;
        cur_len_q <= ext_len;
      end else begin
        cur_len_q <= '0;
      end
      if (closing) begin
        seen_q <= 1'b1;
        // first run at phase 0 and a later run ending at the top wait for the merge decision
        if (!seen_q && c_start == '0) begin
          first_def_o <= 1'b1;
          first_len_o <= c_len;
        end else if (seen_q && bit_i && at_end) begin
          last_def_o   <= 1'b1;
          last_start_o <= c_start;
          last_len_o   <= c_len;
        end else if (c_len > best_len_o) begin
          best_start_o <= c_start;
          best_len_o   <= c_len;
        end
      end
    end
  end
endmodule

// File: rtl/phsel_pick.sv
module phsel_pick #(
  parameter int NPH = 16,
  parameter int PW  = $clog2(NPH),
  parameter int LW  = $clog2(NPH + 1)
) (
  input  logic          first_def_i,
  input  logic [LW-1:0] first_len_i,
  input  logic          last_def_i,
  input  logic [PW-1:0] last_start_i,
  input  logic [LW-1:0] last_len_i,
  input  logic [PW-1:0] best_start_i,
  input  logic [LW-1:0] best_len_i,
  output logic [PW-1:0] phase_o,
  output logic          err_o
);
  localparam int SW = LW + 1;
  localparam int XW = LW + 3;

  logic          merge;
  logic [SW-1:0] merged_len, sel_len;
  logic [PW-1:0] sel_start;
  logic [XW-1:0] prod, idx_raw, idx;

  assign merge      = first_def_i && last_def_i;
  assign merged_len = {1'b0, first_len_i} + {1'b0, last_len_i};

  always_comb begin
    sel_start = best_start_i;
    sel_len   = {1'b0, best_len_i};
    if (merge) begin
      if (merged_len > sel_len) begin
        sel_start = last_start_i;
        sel_len   = merged_len;
      end
    end else begin
      // earliest run keeps ties, latest run must be strictly longer
      if (first_def_i && {1'b0, first_len_i} >= sel_len) begin
        sel_start = '0;
        sel_len   = {1'b0, first_len_i};
      end
      if (last_def_i && {1'b0, last_len_i} > sel_len) begin
        sel_start = last_start_i;
        sel_len   = {1'b0, last_len_i};
      end
    end
  end

  assign prod    = {2'b00, sel_len} * XW'(3);
  assign idx_raw = prod >> 2;
  assign idx     = (idx_raw != '0) ? idx_raw - 1'b1 : '0;
  assign phase_o = sel_start + PW'(idx);
  assign err_o   = (sel_len == '0) || (merge && merged_len >= SW'(NPH));
endmodule

// File: rtl/phase_window_select.sv
module phase_window_select #(
  parameter  int NPH = 16,
  localparam int PW  = $clog2(NPH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [NPH-1:0] mask_i,
  output logic           done_o,
  output logic           valid_o,
  output logic           err_o,
  output logic [PW-1:0]  phase_o
);
  import phsel_pkg::*;
  localparam int LW = $clog2(NPH + 1);

  scan_state_e    state_q;
  logic [NPH-1:0] mask_q;
  logic [PW-1:0]  pos_q;
  logic           accept, step;

  logic          first_def, last_def;
  logic [LW-1:0] first_len, last_len, best_len;
  logic [PW-1:0] last_start, best_start, pick_phase;
  logic          pick_err;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign step   = (state_q == ST_SCAN);

  phsel_run_tracker #(.NPH(NPH), .PW(PW), .LW(LW)) i_tracker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (accept),
    .step_i       (step),
    .bit_i        (mask_q[pos_q]),
    .pos_i        (pos_q),
    .first_def_o  (first_def),
    .first_len_o  (first_len),
    .last_def_o   (last_def),
    .last_start_o (last_start),
    .last_len_o   (last_len),
    .best_start_o (best_start),
    .best_len_o   (best_len)
  );

  phsel_pick #(.NPH(NPH), .PW(PW), .LW(LW)) i_pick (
    .first_def_i  (first_def),
    .first_len_i  (first_len),
    .last_def_i   (last_def),
    .last_start_i (last_start),
    .last_len_i   (last_len),
    .best_start_i (best_start),
    .best_len_i   (best_len),
    .phase_o      (pick_phase),
    .err_o        (pick_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      pos_q   <= '0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      phase_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mask_q  <= mask_i;
          pos_q   <= '0;
          valid_o <= 1'b0;
          err_o   <= 1'b0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          pos_q <= pos_q + 1'b1;
          if (pos_q == PW'(NPH - 1)) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_o  <= 1'b1;
          valid_o <= ~pick_err;
          err_o   <= pick_err;
          phase_o <= pick_err ? '0 : pick_phase;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_window_select_chk.sv
module phase_window_select_chk #(
  parameter  int NPH = 16,
  localparam int PW  = $clog2(NPH)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           accept,
  input logic [NPH-1:0] mask_q,
  input logic           done_o,
  input logic           valid_o,
  input logic           err_o,
  input logic [PW-1:0]  phase_o
);
  localparam int LAT = NPH + 2;
  localparam int CW  = $clog2(LAT + 2);
  localparam int ONES_PICK = (NPH * 3) / 4 - 1;

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   lat_cnt <= '0;
    else if (accept)                               lat_cnt <= CW'(1);
    else if (done_o)                               lat_cnt <= '0;
    else if (lat_cnt != '0 && lat_cnt < CW'(LAT))  lat_cnt <= lat_cnt + 1'b1;
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_cnt == CW'(LAT));

  p_err_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o == (mask_q == '0)));

  p_flags_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_o != err_o));

  p_pick_passing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> mask_q[phase_o]);

  p_all_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mask_q == '1) |-> phase_o == PW'(ONES_PICK));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> (done_o || $stable(phase_o)));
endmodule

bind phase_window_select phase_window_select_chk #(.NPH(NPH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .accept  (accept),
  .mask_q  (mask_q),
  .done_o  (done_o),
  .valid_o (valid_o),
  .err_o   (err_o),
  .phase_o (phase_o)
);

// File: tb/test_phase_window_select.sv
`timescale 1ns/1ps
module test_phase_window_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        done_o, valid_o, err_o;
  logic [3:0]  phase_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  phase_window_select i_phase_window_select (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mask_i(mask_i),
    .done_o(done_o), .valid_o(valid_o), .err_o(err_o), .phase_o(phase_o)
  );

  // behavioural reference: list of runs, wrap merge, longest earliest, 3/4 pick
  function automatic void ref_pick(input logic [15:0] m, output int ph, output bit er);
    int st[$];
    int ln[$];
    int bl, bs, i, last;
    st = {}; ln = {};
    for (int p = 0; p < 16; p++) begin
      if (m[p]) begin
        if (p == 0 || !m[p-1]) begin st.push_back(p); ln.push_back(1); end
        else ln[ln.size()-1] = ln[ln.size()-1] + 1;
      end
    end
    ph = 0; er = 0;
    if (st.size() == 0) begin er = 1; return; end
    last = st.size() - 1;
    if (st[0] == 0 && last > 0 && st[last] + ln[last] == 16) begin
      if (ln[0] + ln[last] >= 16) begin er = 1; return; end
      ln[last] = ln[last] + ln[0];
      ln[0] = 0;
    end
    bl = 0; bs = 0;
    for (int k = 0; k <= last; k++) if (ln[k] > bl) begin bl = ln[k]; bs = st[k]; end
    i = (bl * 3) / 4;
    if (i != 0) i--;
    ph = (bs + i) % 16;
  endfunction

  int          m_left = 0;
  logic [15:0] m_mask = '0;
  bit          e_done = 0, e_valid = 0, e_err = 0;
  int          e_phase = 0;

  always @(posedge clk or negedge rst_n) begin
    int ph; bit er;
    if (!rst_n) begin
      m_left = 0; e_done = 0; e_valid = 0; e_err = 0; e_phase = 0;
    end else begin
      e_done = 0;
      if (m_left == 1) begin
        m_left = 0;
        ref_pick(m_mask, ph, er);
        e_done = 1; e_valid = !er; e_err = er; e_phase = er ? 0 : ph;
      end else if (m_left > 1) begin
        m_left--;
      end else if (start_i) begin
        m_mask = mask_i; m_left = 17; e_valid = 0; e_err = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done_o == e_done, "R7 done timing", done_o, e_done);
      chk(valid_o == e_valid && err_o == e_err, "R5/R8 flags",
          {valid_o, err_o}, {e_valid, e_err});
      chk(int'(phase_o) == e_phase, "R4 phase", phase_o, e_phase);
    end
  end

  task automatic run_case(input logic [15:0] m, input int exp_ph, input bit exp_er, input string req);
    @(negedge clk);
    mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (17) @(negedge clk);
    chk(done_o == 1'b1, {req, " done"}, done_o, 1);
    chk(err_o == exp_er && valid_o == !exp_er, {req, " flags"}, err_o, exp_er);
    if (!exp_er) chk(int'(phase_o) == exp_ph, {req, " phase"}, phase_o, exp_ph);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(done_o == 0 && valid_o == 0 && err_o == 0 && phase_o == 0, "R9 reset",
        {done_o, valid_o, err_o, phase_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case(16'h0000, 0, 1, "R5 empty");
    run_case(16'hFFFF, 11, 0, "R6 all ones");
    run_case(16'h0001, 0, 0, "R1 single low");
    run_case(16'h8000, 15, 0, "R1 single high");
    run_case(16'h8001, 15, 0, "R2 merge pair");
    run_case(16'hC003, 0, 0, "R2 merge wrap pick");
    run_case(16'hF00F, 1, 0, "R2 merge eight");
    run_case(16'hC1E3, 7, 0, "R3 tie middle beats merged");
    run_case(16'h0F0F, 2, 0, "R3 tie earliest");
    run_case(16'h00F0, 6, 0, "R4 len4");
    run_case(16'h0FF0, 9, 0, "R4 len8");
    run_case(16'h7FFE, 10, 0, "R4 len14");
    run_case(16'hFFFE, 11, 0, "R4 len15 top");
    run_case(16'h7FFF, 10, 0, "R4 len15 bottom");
    run_case(16'h0006, 1, 0, "R4 len2");

    // R8: start during a scan is ignored
    @(negedge clk);
    mask_i = 16'h00F0; start_i = 1'b1;
    @(negedge clk);
    mask_i = 16'h0000;
    @(negedge clk);
    start_i = 1'b0;
    repeat (16) @(negedge clk);
    chk(done_o == 1'b1 && valid_o == 1'b1, "R8 busy start ignored", {done_o, valid_o}, 3);
    chk(phase_o == 4'd6, "R8 busy start ignored phase", phase_o, 6);
    repeat (20) @(negedge clk);
    chk(done_o == 1'b0 && phase_o == 4'd6, "R8 hold after done", phase_o, 6);

    for (int n = 0; n < 60; n++) begin
      int ph; bit er;
      logic [15:0] m;
      m = 16'($urandom);
      if (n % 3 == 0) m = m & 16'($urandom);
      ref_pick(m, ph, er);
      run_case(m, ph, er, "R1 random");
    end

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule